// File: doc/BRIEF.md
# GPIO Port Data Register Bank

This block is the data side of one 32-pin general-purpose I/O port, reached over a simple single-cycle register bus. It keeps an output latch with one bit per pin. Software changes the latch through four word views: a data view that loads the whole latch, and set, clear and toggle views that change only the bits written as 1. Software can therefore change individual pins without a read-modify-write sequence.

Each pad drives its latch bit only when the pin is muxed to GPIO and its direction is output. The mux-select and direction bits arrive as static inputs from elsewhere. A pin that is not enabled keeps its latched value undriven, and that value appears on the pad as soon as the pin is enabled. A read of the data view does not return the latch. It returns the level on the pad, passed through a two-flop synchronizer and a glitch filter. The filter takes samples every PRESCALE clocks and accepts a level only after QUAL_N equal samples in a row.

Because the data view reads the pad and not the latch, a read-modify-write through that view can corrupt the latch bit of a pin whose pad is held at the other level from outside. The set, clear and toggle views do not have this problem.

Top module: `gpio_port_bank`

## Requirements
- R1: `bus_addr` is a word address. Word 0 selects the data view, word 2 the set view, word 4 the clear view and word 6 the toggle view. A write (`bus_sel`=1, `bus_we`=1) to any other address leaves the latch unchanged.
- R2: A write to the data view loads all 32 latch bits with `bus_wdata`. The new value is on `pad_out` after the clock edge that takes the write.
- R3: In a write to the set view, each `bus_wdata` bit at 1 makes its latch bit 1. In the clear view each 1 makes the latch bit 0, and in the toggle view each 1 inverts the latch bit. Latch bits whose `bus_wdata` bit is 0 keep their value.
- R4: While `bus_sel`=1 and `bus_we`=0, `bus_rdata` returns the qualified pad level at word 0, whatever `pin_gpio` and `pin_out_en` hold. It returns 0 at every other address, the set, clear and toggle views included. `bus_rdata` is 0 when no read is in progress. `bus_rdata` is combinational from the bus inputs and the qualified register.
- R5: `pad_oe[n]` is 1 exactly when `pin_gpio[n]`=1 and `pin_out_en[n]`=1, in the same cycle. `pad_out[n]` always carries latch bit n.
- R6: A latch bit written while its pin is not enabled is kept. It appears driven on the pad in the same cycle the pin becomes enabled, with no further write.
- R7: With QUAL_N≥1, the qualified bit takes the synchronized pad level once QUAL_N consecutive samples, taken every PRESCALE clocks, have been equal. With QUAL_N=0 the pad level appears on `bus_rdata` after the third clock edge that follows the pad change.
- R8: Reset clears the output latch and the qualified input register to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address of the view |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| pin_gpio | input | 32 | Per-pin mux select, 1 = GPIO |
| pin_out_en | input | 32 | Per-pin direction, 1 = output |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Output latch toward the pads |
| pad_oe | output | 32 | Per-pin pad drive enable |

## Verification
The latch views are tried with patterns that overlap and with complementary patterns. A wrong view decode then shows as a different bit pattern, and the test separates set from toggle and clear from a data load. Pad inputs are driven in three ways: held steady, as one-clock glitches, and as random changes. The steady levels measure the filter latency, and the glitches confirm that no spike shorter than the qualification window gets through. A pin held at the opposite level from its latch shows that a read-modify-write through the data view loses the bit, while the set view keeps it. A random bus and pad phase is compared every clock against a behavioural model for latch, drive enable and read data.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    typedef enum logic [2:0] {
        VIEW_NONE,
        VIEW_DATA,
        VIEW_SET,
        VIEW_CLR,
        VIEW_TGL
    } view_e;

    localparam int unsigned WORD_DATA = 0;
    localparam int unsigned WORD_SET  = 2;
    localparam int unsigned WORD_CLR  = 4;
    localparam int unsigned WORD_TGL  = 6;

    function automatic view_e decode_view(input int unsigned word);
        case (word)
            WORD_DATA: decode_view = VIEW_DATA;
            WORD_SET:  decode_view = VIEW_SET;
            WORD_CLR:  decode_view = VIEW_CLR;
            WORD_TGL:  decode_view = VIEW_TGL;
            default:   decode_view = VIEW_NONE;
        endcase
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.s2;
endmodule

// File: rtl/gpio_qual.sv
module gpio_qual #(
    parameter int W        = 32,
    parameter int QUAL_N   = 3,
    parameter int PRESCALE = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] qout
);
    generate
        if (QUAL_N == 0) begin : g_pass
            logic [W-1:0] q_d, q_q;

            always_comb q_d = din;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) q_q <= '0;
                else        q_q <= q_d;
            end

            assign qout = q_q;
        end else begin : g_filt
            localparam int CW = $clog2(QUAL_N + 1);
            localparam int PW = (PRESCALE < 2) ? 1 : $clog2(PRESCALE);

            typedef struct packed {
                logic [PW-1:0]         pc;
                logic [W-1:0]          last;
                logic [W-1:0][CW-1:0]  run;
                logic [W-1:0]          q;
            } qual_t;

            qual_t st_d, st_q;
            logic  tick_w;

            assign tick_w = (st_q.pc == PW'(PRESCALE - 1));

            always_comb begin
                st_d    = st_q;
                st_d.pc = tick_w ? '0 : st_q.pc + 1'b1;
                if (tick_w) begin
                    for (int i = 0; i < W; i++) begin
                        if (din[i] == st_q.last[i]) begin
                            if (st_q.run[i] < CW'(QUAL_N))
                                st_d.run[i] = st_q.run[i] + 1'b1;
                        end else begin
                            st_d.run[i] = CW'(1);
                        end
                        st_d.last[i] = din[i];
                        if (st_d.run[i] == CW'(QUAL_N))
                            st_d.q[i] = din[i];
                    end
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end

            assign qout = st_q.q;

            // R7: the filtered value moves only on a sample tick
            assert_qual_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
                !tick_w |=> $stable(st_q.q));
        end
    endgenerate
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch
    import gpio_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  view_e        view,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] latch
);
    typedef struct packed {
        logic [W-1:0] lat;
    } lat_t;

    lat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (view)
                VIEW_DATA: st_d.lat = wdata;
                VIEW_SET:  st_d.lat = st_q.lat | wdata;
                VIEW_CLR:  st_d.lat = st_q.lat & ~wdata;
                VIEW_TGL:  st_d.lat = st_q.lat ^ wdata;
                default:   st_d.lat = st_q.lat;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign latch = st_q.lat;

    // R1: no write strobe, no latch change
    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q.lat));

    // R3: set view forces written ones high
    assert_set_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && view == VIEW_SET) |=> ((st_q.lat & $past(wdata)) == $past(wdata)));

    // R3: clear view forces written ones low
    assert_clr_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && view == VIEW_CLR) |=> ((st_q.lat & $past(wdata)) == '0));

    // R3: toggle view flips exactly the written ones
    assert_tgl_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && view == VIEW_TGL) |=> ((st_q.lat ^ $past(st_q.lat)) == $past(wdata)));
endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
    import gpio_pkg::*;
#(
    parameter int W        = 32,
    parameter int ADDR_W   = 4,
    parameter int QUAL_N   = 3,
    parameter int PRESCALE = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pin_gpio,
    input  logic [W-1:0]      pin_out_en,
    input  logic [W-1:0]      pad_in,
    output logic [W-1:0]      pad_out,
    output logic [W-1:0]      pad_oe
);
    view_e        view_w;
    logic         wr_w;
    logic         rd_w;
    logic [W-1:0] sync_w;
    logic [W-1:0] qual_w;
    logic [W-1:0] latch_w;

    assign view_w = decode_view(int'(bus_addr));
    assign wr_w   = bus_sel && bus_we;
    assign rd_w   = bus_sel && !bus_we;

    gpio_sync #(.W(W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (sync_w)
    );

    gpio_qual #(.W(W), .QUAL_N(QUAL_N), .PRESCALE(PRESCALE)) u_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sync_w),
        .qout  (qual_w)
    );

    gpio_out_latch #(.W(W)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_w),
        .view  (view_w),
        .wdata (bus_wdata),
        .latch (latch_w)
    );

    always_comb begin
        bus_rdata = '0;
        if (rd_w && view_w == VIEW_DATA)
            bus_rdata = qual_w;
    end

    assign pad_out = latch_w;
    assign pad_oe  = pin_gpio & pin_out_en;

    // R4: write-only views never return data
    assert_wo_views_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_w && view_w != VIEW_DATA) |-> (bus_rdata == '0));
endmodule

// File: tb/sim_gpio_port_bank.sv
`timescale 1ns/1ps
module sim_gpio_port_bank;
    localparam int W  = 32;
    localparam int QN = 3;
    localparam int PS = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, we = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0, rdata, rdata1;
    logic [31:0] gsel = '0, dir = '0, pad_in = '0;
    logic [31:0] pout, poe, pout1, poe1;

    int total = 0;
    int bad   = 0;
    bit mon_on = 1'b0;

    always #2.5 clk = ~clk;

    gpio_port_bank #(.W(W), .ADDR_W(4), .QUAL_N(QN), .PRESCALE(PS)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .pin_gpio(gsel), .pin_out_en(dir),
        .pad_in(pad_in), .pad_out(pout), .pad_oe(poe));

    gpio_port_bank #(.W(W), .ADDR_W(4), .QUAL_N(0), .PRESCALE(1)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_sel(1'b1), .bus_we(1'b0), .bus_addr(4'd0),
        .bus_wdata(32'd0), .bus_rdata(rdata1), .pin_gpio(gsel), .pin_out_en(dir),
        .pad_in(pad_in), .pad_out(pout1), .pad_oe(poe1));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_lat, m_q, m_s1, m_s2;
    bit          m_last [32];
    int          m_run  [32];
    int          m_pc;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lat = '0; m_q = '0; m_s1 = '0; m_s2 = '0; m_pc = 0;
            for (int i = 0; i < 32; i++) begin m_last[i] = 1'b0; m_run[i] = 0; end
        end else begin
            bit tk;
            tk = (m_pc == PS - 1);
            m_pc = tk ? 0 : m_pc + 1;
            if (tk) begin
                for (int i = 0; i < 32; i++) begin
                    if (m_s2[i] == m_last[i]) m_run[i] = (m_run[i] < QN) ? m_run[i] + 1 : QN;
                    else                      m_run[i] = 1;
                    m_last[i] = m_s2[i];
                    if (m_run[i] >= QN) m_q[i] = m_s2[i];
                end
            end
            m_s2 = m_s1;
            m_s1 = pad_in;
            if (sel && we) begin
                case (addr)
                    4'd0: m_lat = wdata;
                    4'd2: m_lat = m_lat | wdata;
                    4'd4: m_lat = m_lat & ~wdata;
                    4'd6: m_lat = m_lat ^ wdata;
                    default: ;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (mon_on) begin
            chk("R2/R3 latch on pad_out", pout, m_lat);
            chk("R5 pad_oe", poe, gsel & dir);
            chk("R4 read data", rdata, (sel && !we && addr == 4'd0) ? m_q : 32'd0);
        end
    end

    // ---------------- bus tasks ----------------
    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        sel = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        sel = 1'b0; we = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        sel = 1'b1; we = 1'b0; addr = a;
        #0.5 d = rdata;
        @(posedge clk); #1;
        sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        #(5.0 * 150000);
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v, exp_l;

        // R8: reset state
        idle(3);
        chk("R8 latch after reset", pout, 32'd0);
        chk("R8 u1 qual after reset", rdata1, 32'd0);
        sel = 1'b1; addr = 4'd0; #0.5;
        chk("R8 qual read after reset", rdata, 32'd0);
        sel = 1'b0;
        rst_n = 1'b1;
        idle(1);
        mon_on = 1'b1;

        // R2 / R6: load while undriven, then enable
        bus_wr(4'd0, 32'hA5A5_0F0F);
        chk("R5 not driven while disabled", poe, 32'd0);
        chk("R6 latch kept undriven", pout, 32'hA5A5_0F0F);
        gsel = 32'hFFFF_0000; dir = 32'h00FF_FF00; #0.5;
        chk("R5 oe needs gpio and output", poe, 32'h00FF_0000);
        gsel = '1; dir = '1; #0.5;
        chk("R6 driven once enabled", poe & pout, 32'hA5A5_0F0F);

        // R3: set / clear / toggle
        exp_l = 32'hA5A5_0F0F;
        bus_wr(4'd2, 32'h0000_00F0); exp_l = exp_l | 32'h0000_00F0;
        chk("R3 set view", pout, exp_l);
        bus_wr(4'd4, 32'h0F00_0001); exp_l = exp_l & ~32'h0F00_0001;
        chk("R3 clear view", pout, exp_l);
        bus_wr(4'd6, 32'hFFFF_0000); exp_l = exp_l ^ 32'hFFFF_0000;
        chk("R3 toggle view", pout, exp_l);
        bus_wr(4'd2, 32'd0);
        chk("R3 zero write to set view", pout, exp_l);

        // R1: unmapped words ignored
        bus_wr(4'd1, 32'h1234_5678);
        chk("R1 odd word ignored", pout, exp_l);
        bus_wr(4'd8, 32'h0);
        chk("R1 word 8 ignored", pout, exp_l);

        // R4: write-only views read zero
        pad_in = '1; idle(20);
        bus_rd(4'd2, v); chk("R4 set view reads 0", v, 32'd0);
        bus_rd(4'd4, v); chk("R4 clear view reads 0", v, 32'd0);
        bus_rd(4'd6, v); chk("R4 toggle view reads 0", v, 32'd0);
        bus_rd(4'd0, v); chk("R4 data view returns pad not latch", v, 32'hFFFF_FFFF);

        // R7: filter latency and glitch rejection
        pad_in = 32'h0000_FFFF; idle(2);
        bus_rd(4'd0, v); chk("R7 not yet qualified", v, 32'hFFFF_FFFF);
        idle(15);
        bus_rd(4'd0, v); chk("R7 qualified after window", v, 32'h0000_FFFF);
        pad_in = 32'hFFFF_FFFF; idle(1); pad_in = 32'h0000_FFFF;
        idle(20);
        bus_rd(4'd0, v); chk("R7 one-clock glitch rejected", v, 32'h0000_FFFF);

        // R7: zero-length filter latency on u1
        @(posedge clk); #1; v = rdata1; pad_in = 32'hC3C3_3C3C;
        @(posedge clk); @(posedge clk); #1;
        chk("R7 N=0 before third edge", rdata1, v);
        @(posedge clk); #1;
        chk("R7 N=0 after third edge", rdata1, 32'hC3C3_3C3C);

        // RMW hazard: pad 1 held low while its latch is 1
        pad_in = 32'd0;
        bus_wr(4'd0, 32'h0000_0002);
        idle(20);
        bus_rd(4'd0, v);
        bus_wr(4'd0, v | 32'h1);
        chk("R4 data-view RMW loses held bit", pout[1:0], 2'b01);
        bus_wr(4'd0, 32'h0000_0002);
        bus_wr(4'd2, 32'h0000_0001);
        chk("R3 set view keeps other bit", pout[1:0], 2'b11);

        // Random phase, checked by the model every clock
        for (int k = 0; k < 600; k++) begin
            @(posedge clk); #1;
            sel = 1'($urandom);
            we = 1'($urandom);
            addr = 4'($urandom % 9);
            wdata = $urandom;
            if ($urandom % 6 == 0) pad_in = $urandom;
            if ($urandom % 20 == 0) begin gsel = $urandom; dir = $urandom; end
        end
        sel = 1'b0; we = 1'b0;
        idle(2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule